// File: doc/BRIEF.md
# Multi-Rail Overcurrent Hiccup Manager

This block watches the digital overcurrent flags of a group of step-down converter rails. It decides whether an overload needs only a restart of the rail concerned or a shutdown of every rail. Each flag passes through a two-stage synchroniser. While a flag stays high, a per-rail window counter advances on each tick of a shared free-running timebase. If the flag falls before the window has filled, that rail alone gets a one-cycle enable drop, which is a local restart. If any window fills, all rails are switched off together for a fixed off period, counted in ticks. After that the block asks the start-up sequencer to run the whole power-up again. An overload that is still present after the restart fills the window again, so the off/restart cycle repeats until the fault clears.

Each rail also has an over-voltage gate on its high-side switch. The gate closes as soon as the feedback comparator reports the upper threshold. It reopens only on a switching-cycle strobe of that rail while the lower-threshold comparator reports that the output has fallen back. The analog thresholds sit outside the block and appear here only as flags.

Top module: `hiccup_mgr`

## Requirements
- R1: After a synchronous reset, every `rail_en` and every `hs_allow` bit is 1 when no over-voltage flags are set. `reseq_req`, `hiccup_active` and `hiccup_pulse` are 0.
- R2: An overcurrent flag is passed through two flip-flops before use. If a flag rises while `tick` is high every cycle, `hiccup_active` is first seen high WIN_TICKS+2 clock cycles later.
- R3: When any rail's flag has been continuously high for WIN_TICKS ticks, all `rail_en` bits go to 0 and `hiccup_active` goes to 1. `hiccup_pulse` is high for exactly one cycle, and this is the first cycle of the off period.
- R4: If a rail's flag falls before its window fills, only that rail's `rail_en` goes low, for exactly one cycle. The other rails stay enabled and no off period starts.
- R5: The off period lasts OFF_TICKS ticks, which is OFF_TICKS cycles when `tick` is high every cycle. All `rail_en` bits stay 0 throughout.
- R6: At the end of the off period, `reseq_req` goes high and all `rail_en` bits return to 1. `reseq_req` drops in the cycle after `seq_done` is sampled high.
- R7: If the overload is still present after the off period, a further off period follows once the window fills again. `hiccup_pulse` gives one pulse for each off period.
- R8: A rail's window counter restarts from zero whenever its flag deasserts. Two bursts that are each shorter than the window do not start an off period, even if their combined length is longer than the window.
- R9: The window advances only on cycles where `tick` is high. An overload of any length with `tick` held low starts no off period.
- R10: A rail's `hs_allow` goes to 0 in the cycle after `ov_above` is sampled high. It returns to 1 only after a cycle in which `ov_below` and `sw_cycle` of that rail are both high and `ov_above` is low. `ov_above` has priority over release.
- R11: `hs_allow` of a rail is 0 whenever its `rail_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase strobe; window and off period count these |
| seq_done | input | 1 | Start-up sequencer reports completion |
| oc_flag | input | NCH | Asynchronous overcurrent flag per rail |
| ov_above | input | NCH | Feedback above upper over-voltage threshold, per rail |
| ov_below | input | NCH | Feedback below lower release threshold, per rail |
| sw_cycle | input | NCH | Start-of-switching-cycle strobe per rail |
| rail_en | output | NCH | Enable per rail |
| hs_allow | output | NCH | High-side switch permission per rail |
| reseq_req | output | 1 | Request to rerun the full start-up sequence |
| hiccup_active | output | 1 | High during the global off period |
| hiccup_pulse | output | 1 | One-cycle pulse per global off event |

## Verification
A window counter that does not clear or that miscounts shows up as an off period that starts too early, too late or not at all. The time from a flag edge to `hiccup_active` exposes such an error within one window length. A wrong off counter changes how many cycles `hiccup_active` stays high, and the off-period length measures that directly. A stuck controller state shows at `reseq_req` or `rail_en` in the first cycle after the off period. Wrong gate state shows on `hs_allow` in the cycle after each over-voltage flag change.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_OFF   = 2'd1,
        ST_RESEQ = 2'd2
    } hic_state_e;

    typedef struct packed {
        logic above;
        logic below;
        logic sw_cycle;
    } ov_flags_t;

    function automatic int cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/hiccup_sync.sv
module hiccup_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q_sync <= '0;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end
endmodule

// File: rtl/hiccup_window.sv
module hiccup_window
    import hiccup_pkg::*;
#(
    parameter int WIN_TICKS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic oc,
    input  logic hold,
    output logic expire,
    output logic restart
);
    localparam int CW = cnt_width(WIN_TICKS);
    localparam logic [CW-1:0] LAST = CW'(WIN_TICKS - 1);

    logic [CW-1:0] cnt;
    logic          oc_prev;

    assign expire = oc && tick && !hold && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            oc_prev <= 1'b0;
            restart <= 1'b0;
        end else begin
            oc_prev <= oc;
            restart <= oc_prev && !oc && !hold;
            if (hold || !oc)
                cnt <= '0;
            else if (tick && cnt != LAST)
                cnt <= cnt + 1'b1;
        end
    end

    // R8
    win_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !oc |=> (cnt == '0));

endmodule

// File: rtl/hiccup_ovgate.sv
module hiccup_ovgate
    import hiccup_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ov_flags_t flags,
    output logic      blocked
);
    always_ff @(posedge clk) begin
        if (rst)
            blocked <= 1'b0;
        else if (flags.above)
            blocked <= 1'b1;
        else if (blocked && flags.below && flags.sw_cycle)
            blocked <= 1'b0;
    end

    // R10
    ov_block_chk: assert property (@(posedge clk) disable iff (rst)
        flags.above |=> blocked);

    // R10
    ov_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (blocked && !(flags.below && flags.sw_cycle)) |=> blocked);

endmodule

// File: rtl/hiccup_mgr.sv
module hiccup_mgr
    import hiccup_pkg::*;
#(
    parameter int NCH       = 3,
    parameter int WIN_TICKS = 16,
    parameter int OFF_TICKS = 12
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick,
    input  logic           seq_done,
    input  logic [NCH-1:0] oc_flag,
    input  logic [NCH-1:0] ov_above,
    input  logic [NCH-1:0] ov_below,
    input  logic [NCH-1:0] sw_cycle,
    output logic [NCH-1:0] rail_en,
    output logic [NCH-1:0] hs_allow,
    output logic           reseq_req,
    output logic           hiccup_active,
    output logic           hiccup_pulse
);
    localparam int OW = cnt_width(OFF_TICKS);
    localparam logic [OW-1:0] OFF_LAST = OW'(OFF_TICKS - 1);

    hic_state_e     state;
    logic [OW-1:0]  off_cnt;
    logic [NCH-1:0] oc_s;
    logic [NCH-1:0] expire;
    logic [NCH-1:0] restart;
    logic [NCH-1:0] blocked;
    logic           hold;

    assign hold = (state == ST_OFF);

    hiccup_sync #(.W(NCH)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (oc_flag),
        .q_sync  (oc_s)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_rail
        ov_flags_t fl;
        assign fl = '{above: ov_above[i], below: ov_below[i], sw_cycle: sw_cycle[i]};

        hiccup_window #(.WIN_TICKS(WIN_TICKS)) u_win (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .oc      (oc_s[i]),
            .hold    (hold),
            .expire  (expire[i]),
            .restart (restart[i])
        );

        hiccup_ovgate u_gate (
            .clk     (clk),
            .rst     (rst),
            .flags   (fl),
            .blocked (blocked[i])
        );

        assign rail_en[i]  = !hold && !restart[i];
        assign hs_allow[i] = rail_en[i] && !blocked[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_RUN;
            off_cnt      <= '0;
            hiccup_pulse <= 1'b0;
        end else begin
            hiccup_pulse <= 1'b0;
            unique case (state)
                ST_RUN, ST_RESEQ: begin
                    if (|expire) begin
                        state        <= ST_OFF;
                        off_cnt      <= '0;
                        hiccup_pulse <= 1'b1;
                    end else if (state == ST_RESEQ && seq_done) begin
                        state <= ST_RUN;
                    end
                end
                ST_OFF: begin
                    if (tick) begin
                        if (off_cnt == OFF_LAST)
                            state <= ST_RESEQ;
                        else
                            off_cnt <= off_cnt + 1'b1;
                    end
                end
                default: state <= ST_RUN;
            endcase
        end
    end

    assign hiccup_active = hold;
    assign reseq_req     = (state == ST_RESEQ);

    // R3
    pulse_in_off_chk: assert property (@(posedge clk) disable iff (rst)
        hiccup_pulse |-> hiccup_active);

    // R6
    off_to_reseq_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(hiccup_active) |-> reseq_req);

    // R11
    gate_follows_en_chk: assert property (@(posedge clk) disable iff (rst)
        (hs_allow & ~rail_en) == '0);

endmodule

// File: tb/hiccup_mgr_test.sv
module hiccup_mgr_test;
    localparam int NCH = 3;
    localparam int WIN = 16;
    localparam int OFF = 12;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           tick = 1'b1;
    logic           seq_done = 1'b0;
    logic [NCH-1:0] oc_flag = '0;
    logic [NCH-1:0] ov_above = '0;
    logic [NCH-1:0] ov_below = '1;
    logic [NCH-1:0] sw_cycle = '0;
    logic [NCH-1:0] rail_en;
    logic [NCH-1:0] hs_allow;
    logic           reseq_req;
    logic           hiccup_active;
    logic           hiccup_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    hiccup_mgr #(.NCH(NCH), .WIN_TICKS(WIN), .OFF_TICKS(OFF)) uut (
        .clk(clk), .rst(rst), .tick(tick), .seq_done(seq_done),
        .oc_flag(oc_flag), .ov_above(ov_above), .ov_below(ov_below),
        .sw_cycle(sw_cycle), .rail_en(rail_en), .hs_allow(hs_allow),
        .reseq_req(reseq_req), .hiccup_active(hiccup_active),
        .hiccup_pulse(hiccup_pulse)
    );

    // {ov_above, ov_below, sw_cycle, expected hs_allow} for rail 0
    localparam logic [3:0] OV_VEC [8] = '{
        4'b0101, 4'b1000, 4'b0010, 4'b0100,
        4'b0111, 4'b1010, 4'b0111, 4'b0001
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        int pulses;
        int low0, low1, low2, hic;
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R1
        check(rail_en == '1, "R1 rail_en", rail_en, 7);
        check(hs_allow == '1, "R1 hs_allow", hs_allow, 7);
        check(!reseq_req && !hiccup_active && !hiccup_pulse, "R1 status", {reseq_req, hiccup_active, hiccup_pulse}, 0);

        // R10 vector walk on rail 0
        foreach (OV_VEC[k]) begin
            ov_above[0] = OV_VEC[k][3];
            ov_below[0] = OV_VEC[k][2];
            sw_cycle[0] = OV_VEC[k][1];
            cyc(1);
            check(hs_allow[0] == OV_VEC[k][0], $sformatf("R10 step %0d", k), hs_allow[0], OV_VEC[k][0]);
            check(hs_allow[2:1] == 2'b11, "R10 other rails", hs_allow[2:1], 3);
        end
        ov_above = '0; ov_below = '1; sw_cycle = '0;

        // R4 short overload on rail 2
        oc_flag[2] = 1'b1;
        cyc(5);
        oc_flag[2] = 1'b0;
        low0 = 0; low1 = 0; low2 = 0; hic = 0;
        for (int k = 0; k < 30; k++) begin
            cyc(1);
            low0 += !rail_en[0]; low1 += !rail_en[1]; low2 += !rail_en[2];
            hic  += hiccup_active;
        end
        check(low2 == 1, "R4 local restart length", low2, 1);
        check(low0 == 0 && low1 == 0, "R4 other rails", low0 + low1, 0);
        check(hic == 0, "R4 no hiccup", hic, 0);

        // R8 two bursts shorter than window
        hic = 0;
        oc_flag[0] = 1'b1; cyc(WIN - 4);
        oc_flag[0] = 1'b0; cyc(3);
        oc_flag[0] = 1'b1; cyc(WIN - 4);
        oc_flag[0] = 1'b0;
        for (int k = 0; k < 10; k++) begin cyc(1); hic += hiccup_active; end
        check(hic == 0, "R8 counter clears", hic, 0);

        // R9 no tick, long overload
        tick = 1'b0;
        hic = 0;
        oc_flag[1] = 1'b1;
        for (int k = 0; k < 3 * WIN; k++) begin cyc(1); hic += hiccup_active; end
        oc_flag[1] = 1'b0;
        cyc(4);
        tick = 1'b1;
        check(hic == 0, "R9 tick gating", hic, 0);

        // R2 R3 long overload
        pulses = 0;
        oc_flag[1] = 1'b1;
        n = 0;
        while (!hiccup_active && n < WIN + 20) begin cyc(1); n++; end
        check(n == WIN + 2, "R2 latency", n, WIN + 2);
        check(hiccup_pulse == 1'b1, "R3 pulse", hiccup_pulse, 1);
        check(rail_en == '0, "R3 rails off", rail_en, 0);
        check(hs_allow == '0, "R11 gate off", hs_allow, 0);
        // R5 off period length
        n = 0; low0 = 0;
        while (hiccup_active && n < OFF + 20) begin
            pulses += hiccup_pulse;
            low0 += (rail_en != '0);
            n++;
            cyc(1);
        end
        check(n == OFF, "R5 off length", n, OFF);
        check(low0 == 0, "R5 rails held off", low0, 0);
        check(pulses == 1, "R3 single pulse", pulses, 1);
        // R6
        check(reseq_req == 1'b1, "R6 reseq request", reseq_req, 1);
        check(rail_en == '1, "R6 rails released", rail_en, 7);

        // R7 overload persists
        n = 0;
        while (!hiccup_active && n < WIN + 20) begin cyc(1); n++; end
        check(hiccup_active == 1'b1, "R7 repeat hiccup", hiccup_active, 1);
        pulses += hiccup_pulse;
        oc_flag[1] = 1'b0;
        n = 0;
        while (hiccup_active && n < OFF + 20) begin cyc(1); n++; end
        check(pulses == 2, "R7 pulse count", pulses, 2);
        check(reseq_req == 1'b1, "R6 reseq second", reseq_req, 1);
        seq_done = 1'b1;
        cyc(1);
        seq_done = 1'b0;
        check(reseq_req == 1'b0, "R6 seq_done clears", reseq_req, 0);
        cyc(3);
        check(rail_en == '1 && !hiccup_active, "R6 normal run", rail_en, 7);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule